// File: doc/BRIEF.md
# Application Register Move Unit

This block carries out moves between a general register file and a bank of application registers. A read move copies the addressed application register out to a general register write port. A write move stores a value into the addressed application register. That value is either a general register operand or an 8-bit immediate sign-extended to the full register width. Every result sent back to the general register side carries a deferred-exception (not-a-thing) tag. A read always clears that tag.

Each application register may be reached only from certain execution-unit types: the memory unit, the integer unit, or both. A per-entry policy parameter sets which. A move from a unit that is not allowed, or a register-form write whose source carries a set deferred-exception tag, is suppressed and reported through a fault flag. A qualifying predicate turns a move into a no-op. All outputs are registered and appear one clock after a single-cycle issue strobe. Moves are serialized, so a read issued on the cycle right after a write to the same entry returns the new value.

Top module: `armove_unit`

## Requirements
- R1: A read move (`mv_to`=0) with a true predicate, issued from an allowed unit, asserts `gr_we` one cycle after issue, and `gr_wdata` carries the addressed entry's contents.
- R2: `gr_wnat` is 0 on every cycle where `gr_we` is 1; a read always clears the destination's deferred-exception tag.
- R3: A register-form write (`mv_to`=1, `mv_imm`=0) with `gr_nat`=0 from an allowed unit stores `gr_val` into the addressed entry.
- R4: An immediate-form write (`mv_to`=1, `mv_imm`=1) stores `imm8` sign-extended from bit 7 to the full width (0x80 becomes 0xFFFF_FFFF_FFFF_FF80).
- R5: A register-form write from an allowed unit with `gr_nat`=1 leaves the entry unchanged and raises `flt_natc` one cycle after issue.
- R6: Access policy: entry i has a 2-bit field at bits [2i+1:2i] of `ACC_POLICY`. Bit 0 allows the memory unit (`unit_sel`=0) and bit 1 allows the integer unit (`unit_sel`=1). In the default policy, i mod 4 = 0 is memory-only, 1 is integer-only, and 2 and 3 allow both. A move from a disallowed unit makes no register update and does not assert `gr_we`, and it raises `flt_illegal`.
- R7: Illegal-operation takes priority over deferred-exception consumption. At most one fault flag is set per move, and a faulting move updates no register.
- R8: With `qp`=0 a move has no effect: no entry changes, and `gr_we`, `flt_illegal` and `flt_natc` stay 0.
- R9: `mv_done` pulses exactly one cycle after each issue. Without an issue, all outputs are 0.
- R10: A read issued on the cycle directly after a successful write to the same entry returns the newly written value.
- R11: After a synchronous reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mv_issue | input | 1 | Single-cycle move strobe |
| qp | input | 1 | Qualifying predicate |
| unit_sel | input | 1 | Issuing unit: 0 memory, 1 integer |
| mv_to | input | 1 | 1 write to application register, 0 read |
| mv_imm | input | 1 | Write source: 1 immediate, 0 general register |
| ar_idx | input | 7 | Application register index |
| gr_val | input | 64 | Source general register value |
| gr_nat | input | 1 | Source deferred-exception tag |
| imm8 | input | 8 | Immediate operand |
| mv_done | output | 1 | Move completed (one cycle after issue) |
| gr_we | output | 1 | General register write enable for read results |
| gr_wdata | output | 64 | Read result |
| gr_wnat | output | 1 | Deferred-exception tag of the result |
| flt_illegal | output | 1 | Illegal-operation fault |
| flt_natc | output | 1 | Deferred-exception consumption fault |

## Verification
The assertions assume that `mv_issue` comes as pulses no longer than one move per cycle, and that the operand fields are stable only while `mv_issue` is high. The read-after-write property also relies on the unit and index of the read being the same as those of the preceding write. The stimulus drives a fresh move or an idle cycle on every falling edge, and it reuses the previous index and unit often enough to produce back-to-back accesses to the same entry. Every index is first written from an allowed unit, so no read ever returns an unwritten entry.

// File: rtl/armove_pkg.sv
package armove_pkg;
  typedef enum logic {UNIT_MEM = 1'b0, UNIT_INT = 1'b1} unit_e;

  // policy field per entry: bit0 memory unit allowed, bit1 integer unit allowed
  localparam logic [1:0] ACC_NONE = 2'b00;
  localparam logic [1:0] ACC_MEM  = 2'b01;
  localparam logic [1:0] ACC_INT  = 2'b10;
  localparam logic [1:0] ACC_BOTH = 2'b11;

  typedef struct packed {
    logic illegal;
    logic natc;
  } fault_t;

  localparam int IMM_W = 8;
endpackage

// File: rtl/armove_perm.sv
module armove_perm
  import armove_pkg::*;
#(
  parameter int N  = 128,
  parameter int IW = $clog2(N),
  parameter logic [2*N-1:0] POLICY = {(N/4){8'hF9}}
) (
  input  logic [IW-1:0] idx,
  input  unit_e         unit,
  output logic          ok
);
  logic [N-1:0] mem_ok;
  logic [N-1:0] int_ok;

  for (genvar i = 0; i < N; i++) begin : g_entry
    assign mem_ok[i] = POLICY[2*i];
    assign int_ok[i] = POLICY[2*i+1];
  end

  always_comb begin
    ok = (unit == UNIT_INT) ? int_ok[idx] : mem_ok[idx];
  end
endmodule

// File: rtl/armove_ctl.sv
module armove_ctl
  import armove_pkg::*;
#(
  parameter int W = 64
) (
  input  logic             issue,
  input  logic             qp,
  input  logic             to_ar,
  input  logic             use_imm,
  input  logic [W-1:0]     gr_val,
  input  logic             gr_nat,
  input  logic [IMM_W-1:0] imm,
  input  logic             ok,
  output logic             ar_we,
  output logic [W-1:0]     ar_wdata,
  output logic             rd_en,
  output fault_t           flt
);
  localparam int EXT_W = W - IMM_W;

  logic act;
  logic [W-1:0] imm_ext;

  always_comb begin
    act     = issue & qp;
    imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    // illegal-operation wins over deferred-exception consumption
    flt.illegal = act & ~ok;
    flt.natc    = act & ok & to_ar & ~use_imm & gr_nat;
    ar_we       = act & ok & to_ar & ~flt.natc;
    ar_wdata    = use_imm ? imm_ext : gr_val;
    rd_en       = act & ok & ~to_ar;
  end
endmodule

// File: rtl/armove_regfile.sv
module armove_regfile #(
  parameter int N  = 128,
  parameter int W  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/armove_unit.sv
module armove_unit
  import armove_pkg::*;
#(
  parameter int N  = 128,
  parameter int W  = 64,
  parameter int IW = $clog2(N),
  parameter logic [2*N-1:0] ACC_POLICY = {(N/4){8'hF9}}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mv_issue,
  input  logic          qp,
  input  logic          unit_sel,
  input  logic          mv_to,
  input  logic          mv_imm,
  input  logic [IW-1:0] ar_idx,
  input  logic [W-1:0]  gr_val,
  input  logic          gr_nat,
  input  logic [7:0]    imm8,
  output logic          mv_done,
  output logic          gr_we,
  output logic [W-1:0]  gr_wdata,
  output logic          gr_wnat,
  output logic          flt_illegal,
  output logic          flt_natc
);
  logic         ok;
  logic         ar_we;
  logic [W-1:0] ar_wdata;
  logic         rd_en;
  fault_t       flt;
  logic [W-1:0] rdata;

  logic   done_q;
  logic   rd_q;
  fault_t flt_q;

  armove_perm #(.N(N), .IW(IW), .POLICY(ACC_POLICY)) u_perm (
    .idx  (ar_idx),
    .unit (unit_e'(unit_sel)),
    .ok   (ok)
  );

  armove_ctl #(.W(W)) u_ctl (
    .issue    (mv_issue & ~rst),
    .qp       (qp),
    .to_ar    (mv_to),
    .use_imm  (mv_imm),
    .gr_val   (gr_val),
    .gr_nat   (gr_nat),
    .imm      (imm8),
    .ok       (ok),
    .ar_we    (ar_we),
    .ar_wdata (ar_wdata),
    .rd_en    (rd_en),
    .flt      (flt)
  );

  armove_regfile #(.N(N), .W(W), .IW(IW)) u_rf (
    .clk   (clk),
    .we    (ar_we),
    .waddr (ar_idx),
    .wdata (ar_wdata),
    .re    (rd_en),
    .raddr (ar_idx),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      flt_q  <= '0;
    end else begin
      done_q <= mv_issue;
      rd_q   <= rd_en;
      flt_q  <= flt;
    end
  end

  always_comb begin
    mv_done     = done_q;
    gr_we       = rd_q;
    gr_wdata    = rd_q ? rdata : '0;
    gr_wnat     = 1'b0;
    flt_illegal = flt_q.illegal;
    flt_natc    = flt_q.natc;
  end
endmodule

// File: rtl/armove_chk.sv
module armove_chk #(
  parameter int W  = 64,
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          mv_issue,
  input logic          qp,
  input logic          unit_sel,
  input logic          mv_to,
  input logic          mv_imm,
  input logic [IW-1:0] ar_idx,
  input logic [W-1:0]  gr_val,
  input logic          gr_nat,
  input logic [7:0]    imm8,
  input logic          mv_done,
  input logic          gr_we,
  input logic [W-1:0]  gr_wdata,
  input logic          gr_wnat,
  input logic          flt_illegal,
  input logic          flt_natc
);
  logic          w_q;
  logic [IW-1:0] w_idx_q;
  logic [W-1:0]  w_val_q;
  logic          w_unit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q      <= 1'b0;
      w_idx_q  <= '0;
      w_val_q  <= '0;
      w_unit_q <= 1'b0;
    end else begin
      w_q      <= mv_issue & qp & mv_to & (mv_imm | ~gr_nat);
      w_idx_q  <= ar_idx;
      w_val_q  <= mv_imm ? {{(W-8){imm8[7]}}, imm8} : gr_val;
      w_unit_q <= unit_sel;
    end
  end

  // R2
  tag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    gr_we |-> !gr_wnat);

  // R5
  nat_consume_chk: assert property (@(posedge clk) disable iff (rst)
    (mv_issue && qp && mv_to && !mv_imm && gr_nat) |=> (!gr_we && (flt_illegal ^ flt_natc)));

  // R7
  one_fault_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flt_illegal, flt_natc}));

  // R7
  fault_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_illegal || flt_natc) |-> !gr_we);

  // R8
  pred_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mv_issue && !qp) |=> (!gr_we && !flt_illegal && !flt_natc));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mv_issue |=> mv_done);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mv_done |-> (!gr_we && !flt_illegal && !flt_natc && gr_wdata == '0));

  // R10
  raw_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (mv_issue && qp && !mv_to && w_q && ar_idx == w_idx_q && unit_sel == w_unit_q)
      |=> (!gr_we || gr_wdata == $past(w_val_q)));
endmodule

bind armove_unit armove_chk #(.W(W), .IW(IW)) u_armove_chk (
  .clk(clk), .rst(rst), .mv_issue(mv_issue), .qp(qp), .unit_sel(unit_sel),
  .mv_to(mv_to), .mv_imm(mv_imm), .ar_idx(ar_idx), .gr_val(gr_val),
  .gr_nat(gr_nat), .imm8(imm8), .mv_done(mv_done), .gr_we(gr_we),
  .gr_wdata(gr_wdata), .gr_wnat(gr_wnat), .flt_illegal(flt_illegal),
  .flt_natc(flt_natc)
);

// File: tb/test_armove_unit.sv
module test_armove_unit;
  localparam int N = 128;
  localparam int W = 64;
  localparam int IW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mv_issue = 1'b0, qp = 1'b0, unit_sel = 1'b0, mv_to = 1'b0, mv_imm = 1'b0;
  logic [IW-1:0] ar_idx = '0;
  logic [W-1:0] gr_val = '0;
  logic gr_nat = 1'b0;
  logic [7:0] imm8 = '0;
  logic mv_done, gr_we, gr_wnat, flt_illegal, flt_natc;
  logic [W-1:0] gr_wdata;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] model [N];
  int last_wr_idx = -1;

  always #2 clk = ~clk;

  armove_unit i_armove_unit (
    .clk(clk), .rst(rst), .mv_issue(mv_issue), .qp(qp), .unit_sel(unit_sel),
    .mv_to(mv_to), .mv_imm(mv_imm), .ar_idx(ar_idx), .gr_val(gr_val),
    .gr_nat(gr_nat), .imm8(imm8), .mv_done(mv_done), .gr_we(gr_we),
    .gr_wdata(gr_wdata), .gr_wnat(gr_wnat), .flt_illegal(flt_illegal),
    .flt_natc(flt_natc)
  );

  function automatic logic allowed(input int idx, input logic unit);
    int p;
    p = idx % 4;
    if (unit) return p != 0;
    return p != 1;
  endfunction

  function automatic logic [W-1:0] sext(input logic [7:0] v);
    return {{(W-8){v[7]}}, v};
  endfunction

  task automatic chk(input logic cond, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic u, input logic to, input logic im, input int idx,
                       input logic [W-1:0] v, input logic nat, input logic [7:0] i8,
                       input logic p);
    logic ok, e_ill, e_nat, e_we;
    logic [W-1:0] e_data;
    string tag;
    @(negedge clk);
    mv_issue = 1'b1; qp = p; unit_sel = u; mv_to = to; mv_imm = im;
    ar_idx = IW'(idx); gr_val = v; gr_nat = nat; imm8 = i8;
    ok    = allowed(idx, u);
    e_ill = p & ~ok;
    e_nat = p & ok & to & ~im & nat;
    e_we  = p & ok & ~to;
    e_data = e_we ? model[idx] : '0;
    if (!p) tag = "R8";
    else if (!to && last_wr_idx == idx) tag = "R10";
    else if (!to) tag = "R1";
    else if (im) tag = "R4";
    else tag = "R3";
    if (p && ok && to && !e_nat) begin
      model[idx] = im ? sext(i8) : v;
      last_wr_idx = idx;
    end else begin
      last_wr_idx = -1;
    end
    @(posedge clk);
    #1;
    chk(mv_done == 1'b1, "R9 done", W'(mv_done), W'(1));
    chk(gr_we == e_we, {tag, " gr_we"}, W'(gr_we), W'(e_we));
    chk(gr_wdata == e_data, {tag, " data"}, gr_wdata, e_data);
    chk(gr_wnat == 1'b0, "R2 nat clear", W'(gr_wnat), W'(0));
    chk(flt_illegal == e_ill, e_ill ? "R6 illegal" : "R7 illegal", W'(flt_illegal), W'(e_ill));
    chk(flt_natc == e_nat, e_ill ? "R7 natc" : "R5 natc", W'(flt_natc), W'(e_nat));
  endtask

  task automatic idle();
    @(negedge clk);
    mv_issue = 1'b0;
    gr_nat = $urandom_range(0, 1);
    @(posedge clk);
    #1;
    chk(!mv_done && !gr_we && !flt_illegal && !flt_natc && gr_wdata == '0,
        "R9 idle", gr_wdata, '0);
    last_wr_idx = -1;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(!mv_done && !gr_we && !flt_illegal && !flt_natc && gr_wdata == '0,
        "R11 reset", gr_wdata, '0);
    @(negedge clk);
    rst = 1'b0;

    // fill every entry from an allowed unit
    for (int i = 0; i < N; i++)
      do_op((i % 4) == 1, 1'b1, 1'b0, i, {$urandom, $urandom}, 1'b0, 8'h0, 1'b1);

    // directed corners
    do_op(1'b0, 1'b1, 1'b1, 2, '0, 1'b0, 8'h80, 1'b1);       // R4 negative
    do_op(1'b0, 1'b0, 1'b0, 2, '0, 1'b0, 8'h0, 1'b1);        // R10, expects ..FF80
    do_op(1'b1, 1'b1, 1'b1, 3, '0, 1'b0, 8'h7F, 1'b1);       // R4 positive
    do_op(1'b1, 1'b0, 1'b0, 3, '0, 1'b0, 8'h0, 1'b1);
    do_op(1'b0, 1'b1, 1'b0, 6, 64'hDEAD, 1'b1, 8'h0, 1'b1);  // R5 suppressed
    do_op(1'b0, 1'b0, 1'b0, 6, '0, 1'b0, 8'h0, 1'b1);
    do_op(1'b1, 1'b1, 1'b0, 4, 64'hBEEF, 1'b1, 8'h0, 1'b1);  // R7 illegal beats natc
    do_op(1'b0, 1'b0, 1'b0, 4, '0, 1'b0, 8'h0, 1'b1);
    do_op(1'b0, 1'b0, 1'b0, 5, '0, 1'b0, 8'h0, 1'b1);        // R6 read disallowed
    do_op(1'b1, 1'b1, 1'b1, 9, '0, 1'b0, 8'h11, 1'b0);       // R8 predicate off
    do_op(1'b1, 1'b0, 1'b0, 9, '0, 1'b0, 8'h0, 1'b1);
    idle();

    // constrained random with frequent index reuse
    begin
      int idx = 0;
      logic u = 1'b0;
      for (int k = 0; k < 4000; k++) begin
        if ($urandom_range(0, 9) < 3) begin
          idle();
        end else begin
          if ($urandom_range(0, 9) >= 4) begin
            idx = $urandom_range(0, N - 1);
            u = $urandom_range(0, 1);
          end
          do_op(u, $urandom_range(0, 1), $urandom_range(0, 1), idx,
                {$urandom, $urandom}, $urandom_range(0, 3) == 0,
                8'($urandom), $urandom_range(0, 7) != 0);
        end
      end
    end

    // R11 reset again mid-run
    @(negedge clk);
    mv_issue = 1'b1; qp = 1'b1; mv_to = 1'b0; unit_sel = 1'b0; ar_idx = '0;
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk(!mv_done && !gr_we && !flt_illegal && !flt_natc, "R11 reset", W'(mv_done), '0);
    @(negedge clk);
    rst = 1'b0; mv_issue = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule